// File: doc/BRIEF.md
# File-Register Execute Unit

This block is the execute stage of a small accumulator-style microcontroller. It takes one decoded instruction at a time: an operation code, an 8-bit file-register selector, a destination bit, an access bit and a 3-bit bit number. For that instruction it reads one byte from an internal data RAM and combines it with the working register W. The result goes either to W or back into the same RAM byte. Byte operations also update a zero flag and a negative flag.

The RAM is split into 256-byte banks that are reached through a bank register. With the access bit clear, the low half of the selector space reaches the bottom of bank 0 and the high half reaches the top of the last bank. With the access bit set, the bank register supplies the upper address bits. A preload port fills the RAM and a bank-write port sets the bank register. Every instruction completes on the clock edge that ends its enabled cycle.

Top module: `fregx_unit`

## Requirements
- R1: Reset (`rst_n` low) clears W, the zero flag, the negative flag and the bank register. RAM keeps its contents.
- R2: Address forming. With `acc`=0 and `fsel`<0x80 the byte is at bank 0, offset `fsel`. With `acc`=0 and `fsel`>=0x80 it is at the last bank, offset `fsel`. With `acc`=1 it is at {bank register, `fsel`}.
- R3: The byte operation codes are 0 ADD (W+f), 1 AND, 2 IOR, 3 XOR, 4 COMF (~f), 5 INCF (f+1), 6 DECF (f-1), 7 MOVF (f) and 8 CLRF (0). All results are modulo 256.
- R4: For a byte operation with `dst`=0, the result is written to W and the RAM byte is left unchanged.
- R5: For a byte operation with `dst`=1, the result is written to the RAM byte and W is left unchanged.
- R6: After a byte operation, the zero flag is 1 exactly when the 8-bit result is 0, and the negative flag equals result bit 7.
- R7: The bit operation codes are 9 (set bit), 10 (clear bit) and 11 (toggle bit). They change only bit `bnum` of the RAM byte, write it back regardless of `dst`, and leave W and both flags unchanged.
- R8: When `en`=0, or when the code is 12 to 15, W, the flags and the RAM are unchanged.
- R9: A bank-register write takes effect on the same clock edge. An instruction issued in that same cycle still uses the old bank value.
- R10: The preload port writes `ld_data` to `ld_addr` on the clock edge. If an instruction writes the same RAM byte in the same cycle, the instruction's value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Execute the presented instruction this cycle |
| op | input | 4 | Operation code |
| fsel | input | 8 | File-register selector |
| dst | input | 1 | Destination: 0 = W, 1 = RAM byte |
| acc | input | 1 | 0 = access window, 1 = banked |
| bnum | input | 3 | Bit number for bit operations |
| bank_we | input | 1 | Load the bank register |
| bank_d | input | BANK_W | New bank register value |
| ld_we | input | 1 | Preload write enable |
| ld_addr | input | BANK_W+8 | Preload RAM address |
| ld_data | input | 8 | Preload data |
| w_q | output | 8 | Working register |
| z_q | output | 1 | Zero flag |
| n_q | output | 1 | Negative flag |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a bank-register load together with a banked instruction. The bench issues both in one cycle and expects the byte from the old bank, then reads from the new bank on the next instruction. The second pair is a preload and an instruction write aimed at the same byte. The bench clears the byte while preloading a nonzero value into it, and judges the result by reading the byte back through a move into W.

// File: rtl/fx_pkg.sv
package fx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [3:0] {
        FX_ADD  = 4'd0,
        FX_AND  = 4'd1,
        FX_IOR  = 4'd2,
        FX_XOR  = 4'd3,
        FX_COMF = 4'd4,
        FX_INCF = 4'd5,
        FX_DECF = 4'd6,
        FX_MOVF = 4'd7,
        FX_CLRF = 4'd8,
        FX_BSET = 4'd9,
        FX_BCLR = 4'd10,
        FX_BTOG = 4'd11,
        FX_RS12 = 4'd12,
        FX_RS13 = 4'd13,
        FX_RS14 = 4'd14,
        FX_RS15 = 4'd15
    } fx_op_e;

    function automatic logic fx_is_byte(input fx_op_e o);
        return (o <= FX_CLRF);
    endfunction

    function automatic logic fx_is_bit(input fx_op_e o);
        return (o == FX_BSET) || (o == FX_BCLR) || (o == FX_BTOG);
    endfunction

endpackage

// File: rtl/fx_addr_gen.sv
module fx_addr_gen #(
    parameter int BANK_W = 2,
    localparam int ADDR_W = BANK_W + 8
) (
    input  logic [7:0]        fsel,
    input  logic              acc,
    input  logic [BANK_W-1:0] bank,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [BANK_W-1:0] TOP_BANK = '1;

    always_comb begin
        if (acc)
            addr = {bank, fsel};
        else if (fsel[7])
            addr = {TOP_BANK, fsel};
        else
            addr = {{BANK_W{1'b0}}, fsel};
    end
endmodule

// File: rtl/fx_alu.sv
module fx_alu
    import fx_pkg::*;
(
    input  fx_op_e             op,
    input  logic [DATA_W-1:0]  wreg,
    input  logic [DATA_W-1:0]  fval,
    input  logic [2:0]         bnum,
    output logic [DATA_W-1:0]  res
);
    logic [DATA_W-1:0] mask;

    always_comb begin
        mask = '0;
        mask[bnum] = 1'b1;
        unique case (op)
            FX_ADD:  res = wreg + fval;
            FX_AND:  res = wreg & fval;
            FX_IOR:  res = wreg | fval;
            FX_XOR:  res = wreg ^ fval;
            FX_COMF: res = ~fval;
            FX_INCF: res = fval + 8'd1;
            FX_DECF: res = fval - 8'd1;
            FX_MOVF: res = fval;
            FX_CLRF: res = '0;
            FX_BSET: res = fval | mask;
            FX_BCLR: res = fval & ~mask;
            FX_BTOG: res = fval ^ mask;
            default: res = fval;
        endcase
    end

    always_comb begin
        if (fx_is_bit(op))
            AST_BIT_SINGLE: assert ($countones(res ^ fval) <= 1); // R7
    end
endmodule

// File: rtl/fx_regfile.sv
module fx_regfile #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ex_we,
    input  logic [DATA_W-1:0] ex_data,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (ld_we && !(ex_we && ld_addr == rd_addr))
            mem[ld_addr] <= ld_data;
        if (ex_we)
            mem[rd_addr] <= ex_data;
    end
endmodule

// File: rtl/fregx_unit.sv
module fregx_unit
    import fx_pkg::*;
#(
    parameter int BANK_W = 2,
    localparam int ADDR_W = BANK_W + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [3:0]        op,
    input  logic [7:0]        fsel,
    input  logic              dst,
    input  logic              acc,
    input  logic [2:0]        bnum,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_d,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    output logic [7:0]        w_q,
    output logic              z_q,
    output logic              n_q
);
    fx_op_e            op_e;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        fval;
    logic [7:0]        res;
    logic              do_byte;
    logic              do_bit;
    logic              ram_we;

    assign op_e    = fx_op_e'(op);
    assign do_byte = en && fx_is_byte(op_e);
    assign do_bit  = en && fx_is_bit(op_e);
    assign ram_we  = do_bit || (do_byte && dst);

    fx_addr_gen #(.BANK_W(BANK_W)) u_addr (
        .fsel (fsel),
        .acc  (acc),
        .bank (bank_q),
        .addr (addr)
    );

    fx_regfile #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
        .clk     (clk),
        .rd_addr (addr),
        .rd_data (fval),
        .ex_we   (ram_we),
        .ex_data (res),
        .ld_we   (ld_we),
        .ld_addr (ld_addr),
        .ld_data (ld_data)
    );

    fx_alu u_alu (
        .op   (op_e),
        .wreg (w_q),
        .fval (fval),
        .bnum (bnum),
        .res  (res)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (bank_we) begin
            bank_q <= bank_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
            z_q <= 1'b0;
            n_q <= 1'b0;
        end else if (do_byte) begin
            if (!dst)
                w_q <= res;
            z_q <= (res == 8'h00);
            n_q <= res[7];
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(w_q) && $stable(z_q) && $stable(n_q)); // R8

    AST_BIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        do_bit |=> $stable(w_q) && $stable(z_q) && $stable(n_q)); // R7

    AST_DST_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_n)
        (do_byte && dst) |=> $stable(w_q)); // R5

    AST_FLAGS_OF_W: assert property (@(posedge clk) disable iff (!rst_n)
        (do_byte && !dst) |=> (z_q == (w_q == 8'h00)) && (n_q == w_q[7])); // R6
endmodule

// File: tb/tb_fregx_unit.sv
module tb_fregx_unit;
    localparam int BANK_W = 2;
    localparam int ADDR_W = BANK_W + 8;
    localparam int NV = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] fsel = '0;
    logic dst = 1'b0, acc = 1'b0;
    logic [2:0] bnum = '0;
    logic bank_we = 1'b0;
    logic [BANK_W-1:0] bank_d = '0;
    logic ld_we = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [7:0] w_q;
    logic z_q, n_q;
    int total = 0, bad = 0;

    always #5 clk = ~clk;

    fregx_unit #(.BANK_W(BANK_W)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .fsel(fsel), .dst(dst),
        .acc(acc), .bnum(bnum), .bank_we(bank_we), .bank_d(bank_d),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .w_q(w_q), .z_q(z_q), .n_q(n_q)
    );

    // {op, fsel, dst, acc, bnum, expected W, expected Z, expected N}
    localparam logic [26:0] VEC [NV] = '{
        {4'd7, 8'h10, 1'b0, 1'b0, 3'd0, 8'h3C, 1'b0, 1'b0},
        {4'd0, 8'h11, 1'b0, 1'b0, 3'd0, 8'hFF, 1'b0, 1'b1},
        {4'd1, 8'h11, 1'b0, 1'b0, 3'd0, 8'hC3, 1'b0, 1'b1},
        {4'd3, 8'h11, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
        {4'd2, 8'h10, 1'b0, 1'b0, 3'd0, 8'h3C, 1'b0, 1'b0},
        {4'd4, 8'h10, 1'b1, 1'b0, 3'd0, 8'h3C, 1'b0, 1'b1},
        {4'd7, 8'h10, 1'b0, 1'b0, 3'd0, 8'hC3, 1'b0, 1'b1},
        {4'd5, 8'h7F, 1'b1, 1'b0, 3'd0, 8'hC3, 1'b1, 1'b0},
        {4'd7, 8'h7F, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
        {4'd6, 8'h7F, 1'b0, 1'b0, 3'd0, 8'hFF, 1'b0, 1'b1},
        {4'd7, 8'h7F, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
        {4'd9, 8'h20, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
        {4'd7, 8'h20, 1'b0, 1'b0, 3'd0, 8'h81, 1'b0, 1'b1},
        {4'd10, 8'h20, 1'b0, 1'b0, 3'd7, 8'h81, 1'b0, 1'b1},
        {4'd7, 8'h20, 1'b0, 1'b0, 3'd0, 8'h01, 1'b0, 1'b0},
        {4'd11, 8'h20, 1'b0, 1'b0, 3'd0, 8'h01, 1'b0, 1'b0},
        {4'd7, 8'h20, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
        {4'd7, 8'h85, 1'b0, 1'b0, 3'd0, 8'h5A, 1'b0, 1'b0},
        {4'd8, 8'h85, 1'b1, 1'b0, 3'd0, 8'h5A, 1'b1, 1'b0},
        {4'd7, 8'h85, 1'b0, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0},
        {4'd0, 8'h10, 1'b1, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1},
        {4'd7, 8'h10, 1'b0, 1'b0, 3'd0, 8'hC3, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] ew, input logic ez, input logic en_);
        total++;
        if (w_q !== ew || z_q !== ez || n_q !== en_) begin
            bad++;
            $display("FAIL %s: got W=%h Z=%b N=%b expected W=%h Z=%b N=%b",
                     req, w_q, z_q, n_q, ew, ez, en_);
        end
    endtask

    task automatic preload(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic issue(input logic [3:0] o, input logic [7:0] f, input logic d,
                         input logic a, input logic [2:0] b);
        @(negedge clk);
        en = 1'b1; op = o; fsel = f; dst = d; acc = a; bnum = b;
        @(negedge clk);
        en = 1'b0; bank_we = 1'b0; ld_we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        bad++; total++;
        $display("FAIL watchdog: got no finish expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", 8'h00, 1'b0, 1'b0);

        preload(10'h010, 8'h3C);
        preload(10'h011, 8'hC3);
        preload(10'h020, 8'h80);
        preload(10'h07F, 8'hFF);
        preload(10'h385, 8'h5A);
        preload(10'h105, 8'h77);
        preload(10'h205, 8'h99);
        preload(10'h285, 8'h44);
        preload(10'h030, 8'h11);
        preload(10'h005, 8'h66);

        // R2 R3 R4 R5 R6 R7 table walk
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][26:23], VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12:10]);
            check($sformatf("R3/R4/R5/R6/R7 row %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R8 idle cycle with a live-looking instruction
        @(negedge clk);
        op = 4'd8; fsel = 8'h10; dst = 1'b0; en = 1'b0;
        @(negedge clk);
        check("R8 en low", 8'hC3, 1'b0, 1'b1);
        // R8 reserved codes
        issue(4'd15, 8'h10, 1'b0, 1'b0, 3'd0);
        check("R8 code 15 W", 8'hC3, 1'b0, 1'b1);
        issue(4'd12, 8'h11, 1'b1, 1'b0, 3'd0);
        issue(4'd7, 8'h11, 1'b0, 1'b0, 3'd0);
        check("R8 code 12 RAM", 8'hC3, 1'b0, 1'b1);

        // R2 R9 banked access and same-cycle bank load
        @(negedge clk);
        bank_we = 1'b1; bank_d = 2'd1;
        @(negedge clk);
        bank_we = 1'b0;
        issue(4'd7, 8'h05, 1'b0, 1'b1, 3'd0);
        check("R2 bank1", 8'h77, 1'b0, 1'b0);
        issue(4'd7, 8'h10, 1'b0, 1'b0, 3'd0);
        @(negedge clk);
        en = 1'b1; op = 4'd7; fsel = 8'h05; dst = 1'b0; acc = 1'b1;
        bank_we = 1'b1; bank_d = 2'd2;
        @(negedge clk);
        en = 1'b0; bank_we = 1'b0;
        check("R9 old bank used", 8'h77, 1'b0, 1'b0);
        issue(4'd7, 8'h05, 1'b0, 1'b1, 3'd0);
        check("R9 new bank", 8'h99, 1'b0, 1'b1);
        issue(4'd7, 8'h85, 1'b0, 1'b1, 3'd0);
        check("R2 acc=1 high selector", 8'h44, 1'b0, 1'b0);

        // R10 preload collides with instruction write
        @(negedge clk);
        en = 1'b1; op = 4'd8; fsel = 8'h30; dst = 1'b1; acc = 1'b0;
        ld_we = 1'b1; ld_addr = 10'h030; ld_data = 8'hAA;
        @(negedge clk);
        en = 1'b0; ld_we = 1'b0;
        issue(4'd7, 8'h30, 1'b0, 1'b0, 3'd0);
        check("R10 instruction wins", 8'h00, 1'b1, 1'b0);

        // R1 reset mid-run clears bank register too
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 second reset", 8'h00, 1'b0, 1'b0);
        issue(4'd7, 8'h05, 1'b0, 1'b1, 3'd0);
        check("R1 bank cleared", 8'h66, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule